// File: doc/BRIEF.md
# Inline-Crypto Keyslot Configuration Register File

This block holds the key-slot entries used by an inline storage-encryption engine. Software programs it over a simple 32-bit word bus with separate write and read strobes. Each slot stores a 512-bit key, an auxiliary word, a data-unit-size bitmask counted in 512-byte units, a capability index and an enable flag. The encryption datapath selects a slot and gets back that slot's key, its size code, its capability index and a valid flag. The flag is high only while the slot's enable flag is set.

A read-only capability word at byte address 0x000 reports the highest slot number and the position of the slot array. The array begins at the pointer field times 0x100 bytes. Each slot takes 128 bytes.

Programming a slot follows a fixed order:
1. Write zero to the control word (dword 16). This turns the slot off.
2. Load the sixteen key dwords and the auxiliary dword 17.
3. Write the control word again with the enable bit set. This is the last step.

While a slot is enabled, the block ignores writes to its key and auxiliary words. The datapath therefore never sees a partly replaced key. Key material never comes back out on the read bus.

Top module: `ks_keyslot_regfile`

## Requirements
- R1: After reset every slot is disabled (`slot_valid` all zero) and every stored word of every slot is zero.
- R2: A read of byte address 0x000 returns NUM_SLOTS-1 in bits [7:0] and ARRAY_PTR in bits [23:16], with all other bits zero. Writes to it have no effect.
- R3: Dword d of slot s sits at byte address ARRAY_PTR*0x100 + s*0x80 + d*4. A write there changes only that slot.
- R4: While a slot is disabled, a write to its dword d (0 to 15) stores the data as key bits [32d+31:32d].
- R5: While a slot is enabled, writes to its key dwords 0 to 15 and to its auxiliary dword 17 are ignored.
- R6: Control dword 16 is always writable. Bit 31 is the enable, bits [15:8] the capability index and bits [7:0] the data-unit-size mask. A write with bit 31 set raises the slot's valid flag at the clock edge that takes the write.
- R7: A write of zero to dword 16 clears the enable, and the valid flag falls at that same edge.
- R8: Reads of key dwords 0 to 15 return zero.
- R9: A read of dword 16 returns the enable, index and mask fields in their positions with every other bit zero. A read of dword 17 returns the full stored word.
- R10: Dwords 18 to 31 of a slot, and addresses outside the capability word and the slot array, read as zero and ignore writes.
- R11: `rdata` takes the addressed value at the clock edge where `rd_en` is sampled high and holds it until the next read.
- R12: The datapath port shows the valid flag, key, size mask and capability index of the slot chosen by `dp_sel`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| slot_valid | output | NUM_SLOTS | Enable flag of every slot |
| dp_sel | input | SLOT_W | Slot chosen by the datapath |
| dp_valid | output | 1 | Enable flag of the chosen slot |
| dp_key | output | 512 | Key of the chosen slot, dword 0 in the low bits |
| dp_dus | output | 8 | Data-unit-size mask of the chosen slot |
| dp_cap | output | 8 | Capability index of the chosen slot |

## Verification
A bad enable flag appears at once on `slot_valid` and `dp_valid`, in the same cycle the wrong state is registered. A key that was wrongly accepted or wrongly locked shows on `dp_key` as soon as that slot is selected. Because key reads return zero, `dp_key` is the only place key corruption can be seen, so the bench compares the whole 512-bit vector after each write sequence. A decode error, such as a wrong stride, base or reserved-word handling, shows one cycle after a read: the auxiliary or control word of some other slot, or a nonzero value, comes back on `rdata`.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int WORD_W      = 32;
  localparam int KEY_DWORDS  = 16;
  localparam int KEY_W       = KEY_DWORDS * WORD_W;
  localparam int STRIDE_DW   = 32;
  localparam int DW_IDX_W    = $clog2(STRIDE_DW);
  localparam int CTRL_DW     = 16;
  localparam int AUX_DW      = 17;
  localparam int FIELD_W     = 8;
  localparam int EN_BIT      = 31;

  typedef struct packed {
    logic               en;
    logic [FIELD_W-1:0] cap;
    logic [FIELD_W-1:0] dus;
  } slot_cfg_t;

  function automatic logic [WORD_W-1:0] cfg_to_word(slot_cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EN_BIT]                 = c.en;
    w[2*FIELD_W-1:FIELD_W]    = c.cap;
    w[FIELD_W-1:0]            = c.dus;
    return w;
  endfunction
endpackage

// File: rtl/ks_addr_decode.sv
module ks_addr_decode
  import ks_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ARRAY_PTR = 1,
  parameter int ADDR_W    = 12,
  parameter int SLOT_W    = 3
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                cap_hit,
  output logic                arr_hit,
  output logic [SLOT_W-1:0]   slot,
  output logic [DW_IDX_W-1:0] dw
);
  localparam int AW        = ADDR_W - 2;
  localparam int BASE_WORD = ARRAY_PTR * 64;
  localparam int END_WORD  = BASE_WORD + NUM_SLOTS * STRIDE_DW;
  localparam logic [AW:0] BASE_L = (AW+1)'(BASE_WORD);
  localparam logic [AW:0] END_L  = (AW+1)'(END_WORD);

  logic [AW-1:0] word;
  logic [AW-1:0] off;
  logic [1:0]    unused_byte_lane;

  assign word             = addr[ADDR_W-1:2];
  assign unused_byte_lane = addr[1:0];
  assign off              = word - BASE_L[AW-1:0];

  always_comb begin
    cap_hit = (word == '0);
    arr_hit = ({1'b0, word} >= BASE_L) && ({1'b0, word} < END_L);
    slot    = off[DW_IDX_W +: SLOT_W];
    dw      = off[DW_IDX_W-1:0];
  end
endmodule

// File: rtl/ks_slot.sv
module ks_slot
  import ks_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_wr,
  input  logic [DW_IDX_W-1:0] dw,
  input  logic [WORD_W-1:0]   wdata,
  output logic [KEY_W-1:0]    key,
  output slot_cfg_t           cfg,
  output logic [WORD_W-1:0]   aux
);
  logic [KEY_DWORDS-1:0][WORD_W-1:0] key_q, key_d;
  slot_cfg_t                         cfg_q, cfg_d;
  logic [WORD_W-1:0]                 aux_q, aux_d;
  logic                              key_we, aux_we, cfg_we;
  logic [EN_BIT-1:2*FIELD_W]         unused_rsvd;

  assign unused_rsvd = wdata[EN_BIT-1:2*FIELD_W];

  // Write permission: key and auxiliary words are frozen while enabled
  always_comb begin
    key_we = sel_wr && (dw < DW_IDX_W'(KEY_DWORDS)) && !cfg_q.en;
    aux_we = sel_wr && (dw == DW_IDX_W'(AUX_DW)) && !cfg_q.en;
    cfg_we = sel_wr && (dw == DW_IDX_W'(CTRL_DW));
  end

  always_comb begin
    key_d = key_q;
    if (key_we) key_d[dw[$clog2(KEY_DWORDS)-1:0]] = wdata;
    aux_d     = wdata;
    cfg_d.en  = wdata[EN_BIT];
    cfg_d.cap = wdata[2*FIELD_W-1:FIELD_W];
    cfg_d.dus = wdata[FIELD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      key_q <= '0;
    else if (key_we) key_q <= key_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      aux_q <= '0;
    else if (aux_we) aux_q <= aux_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign key = key_q;
  assign cfg = cfg_q;
  assign aux = aux_q;

  a_r5_key_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && cfg_q.en && dw < DW_IDX_W'(KEY_DWORDS)) |=> $stable(key_q));
  a_r5_aux_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && cfg_q.en && dw == DW_IDX_W'(AUX_DW)) |=> $stable(aux_q));
  a_r6_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && dw == DW_IDX_W'(CTRL_DW) && wdata[EN_BIT]) |=> cfg.en);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr && dw == DW_IDX_W'(CTRL_DW) && wdata == '0) |=> !cfg.en);
endmodule

// File: rtl/ks_rd_mux.sv
module ks_rd_mux
  import ks_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ARRAY_PTR = 1,
  parameter int SLOT_W    = 3
) (
  input  logic                cap_hit,
  input  logic                arr_hit,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [DW_IDX_W-1:0] dw,
  input  slot_cfg_t           cfg_a [NUM_SLOTS],
  input  logic [WORD_W-1:0]   aux_a [NUM_SLOTS],
  output logic [WORD_W-1:0]   rd_val
);
  logic [WORD_W-1:0] cap_word;

  always_comb begin
    cap_word         = '0;
    cap_word[7:0]    = 8'(NUM_SLOTS - 1);
    cap_word[23:16]  = 8'(ARRAY_PTR);
  end

  always_comb begin
    rd_val = '0;
    if (cap_hit) begin
      rd_val = cap_word;
    end else if (arr_hit && (int'(slot) < NUM_SLOTS)) begin
      if (dw == DW_IDX_W'(CTRL_DW))     rd_val = cfg_to_word(cfg_a[slot]);
      else if (dw == DW_IDX_W'(AUX_DW)) rd_val = aux_a[slot];
    end
  end
endmodule

// File: rtl/ks_keyslot_regfile.sv
module ks_keyslot_regfile
  import ks_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ARRAY_PTR = 1,
  parameter int ADDR_W    = 12,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic [NUM_SLOTS-1:0] slot_valid,
  input  logic [SLOT_W-1:0]    dp_sel,
  output logic                 dp_valid,
  output logic [511:0]         dp_key,
  output logic [7:0]           dp_dus,
  output logic [7:0]           dp_cap
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                cap_hit, arr_hit;
  logic [SLOT_W-1:0]   dec_slot;
  logic [DW_IDX_W-1:0] dec_dw;

  ks_addr_decode #(
    .NUM_SLOTS(NUM_SLOTS), .ARRAY_PTR(ARRAY_PTR),
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)
  ) i_dec (
    .addr(addr), .cap_hit(cap_hit), .arr_hit(arr_hit),
    .slot(dec_slot), .dw(dec_dw)
  );

  logic [KEY_W-1:0]  key_a [NUM_SLOTS];
  slot_cfg_t         cfg_a [NUM_SLOTS];
  logic [WORD_W-1:0] aux_a [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic sel_wr;
    assign sel_wr = wr_en && arr_hit && (dec_slot == SLOT_W'(s));
    ks_slot i_slot (
      .clk(clk), .rst_n(rst_int_n), .sel_wr(sel_wr), .dw(dec_dw),
      .wdata(wdata), .key(key_a[s]), .cfg(cfg_a[s]), .aux(aux_a[s])
    );
    assign slot_valid[s] = cfg_a[s].en;
  end

  logic [WORD_W-1:0] rd_val, rdata_q;

  ks_rd_mux #(
    .NUM_SLOTS(NUM_SLOTS), .ARRAY_PTR(ARRAY_PTR), .SLOT_W(SLOT_W)
  ) i_rmux (
    .cap_hit(cap_hit), .arr_hit(arr_hit), .slot(dec_slot), .dw(dec_dw),
    .cfg_a(cfg_a), .aux_a(aux_a), .rd_val(rd_val)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_val;
  end
  assign rdata = rdata_q;

  // Datapath view of the selected slot
  always_comb begin
    dp_valid = 1'b0;
    dp_key   = '0;
    dp_dus   = '0;
    dp_cap   = '0;
    if (int'(dp_sel) < NUM_SLOTS) begin
      dp_valid = cfg_a[dp_sel].en;
      dp_key   = key_a[dp_sel];
      dp_dus   = cfg_a[dp_sel].dus;
      dp_cap   = cfg_a[dp_sel].cap;
    end
  end

  a_r8_key_hidden: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && arr_hit && dec_dw < DW_IDX_W'(KEY_DWORDS)) |=> (rdata == '0));
  a_r2_cap_count: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && cap_hit) |=> (rdata[7:0] == 8'(NUM_SLOTS - 1)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_en |=> $stable(rdata));
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_en && !cap_hit && !arr_hit) |=> (rdata == '0));
endmodule

// File: tb/test_ks_keyslot_regfile.sv
module test_ks_keyslot_regfile;
  localparam int NS = 8;
  localparam int AP = 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, rd_en;
  logic [11:0]  addr;
  logic [31:0]  wdata, rdata;
  logic [NS-1:0] slot_valid;
  logic [2:0]   dp_sel;
  logic         dp_valid;
  logic [511:0] dp_key;
  logic [7:0]   dp_dus, dp_cap;

  always #10 clk = ~clk;

  ks_keyslot_regfile #(.NUM_SLOTS(NS), .ARRAY_PTR(AP), .ADDR_W(12)) i_ks_keyslot_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .slot_valid(slot_valid), .dp_sel(dp_sel),
    .dp_valid(dp_valid), .dp_key(dp_key), .dp_dus(dp_dus), .dp_cap(dp_cap)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t q[$];
  logic pend = 1'b0;

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] sa(int s, int d);
    return 12'(AP * 256 + s * 128 + d * 4);
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    rd_item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Monitor: notes a read at the edge, compares half a cycle later
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend) begin
      if (q.size() == 0) chk("monitor", 512'(rdata), 512'hBAD);
      else begin
        rd_item_t it;
        it = q.pop_front();
        chk(it.tag, 512'(rdata), 512'(it.exp));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  logic [15:0][31:0] exp_key;

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; dp_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 slot_valid", 512'(slot_valid), 512'h0);
    rd(sa(0, 16), 32'h0, "R1 ctrl zero");
    rd(sa(5, 17), 32'h0, "R1 aux zero");
    dp_sel = 3'd3;
    #1 chk("R1 key zero", dp_key, 512'h0);

    // R2 capability word, write ignored
    rd(12'h000, 32'h0001_0007, "R2 cap");
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h0001_0007, "R2 cap after write");

    // R4 load slot 2 key while disabled, then R6 enable
    wr(sa(2, 16), 32'h0);
    for (int i = 0; i < 16; i++) begin
      exp_key[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0101;
      wr(sa(2, i), exp_key[i]);
    end
    wr(sa(2, 17), 32'hA5A5_0002);
    chk("R6 not valid before ctrl", 512'(slot_valid), 512'h0);
    wr(sa(2, 16), 32'h8F0F_0302);
    chk("R6 slot_valid", 512'(slot_valid), 512'h4);
    dp_sel = 3'd2;
    #1;
    chk("R12 dp_valid", 512'(dp_valid), 512'h1);
    chk("R4 R12 dp_key", dp_key, exp_key);
    chk("R12 dp_dus", 512'(dp_dus), 512'h02);
    chk("R12 dp_cap", 512'(dp_cap), 512'h03);
    rd(sa(2, 16), 32'h8000_0302, "R9 ctrl readback");
    rd(sa(2, 17), 32'hA5A5_0002, "R9 aux readback");
    rd(sa(2, 5), 32'h0, "R8 key hidden");
    rd(sa(2, 0), 32'h0, "R8 key hidden dw0");

    // R11 hold
    rd(sa(2, 17), 32'hA5A5_0002, "R11 read");
    repeat (3) @(negedge clk);
    chk("R11 rdata held", 512'(rdata), 512'hA5A5_0002);

    // R5 writes ignored while enabled
    wr(sa(2, 0), 32'hDEAD_BEEF);
    wr(sa(2, 15), 32'hDEAD_BEEF);
    wr(sa(2, 17), 32'h1234_5678);
    #1 chk("R5 key locked", dp_key, exp_key);
    rd(sa(2, 17), 32'hA5A5_0002, "R5 aux locked");

    // R10 reserved dwords and unmapped space
    wr(sa(2, 20), 32'hFFFF_FFFF);
    rd(sa(2, 20), 32'h0, "R10 reserved dw");
    rd(sa(2, 31), 32'h0, "R10 reserved dw31");
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h800, 32'h0, "R10 unmapped");
    rd(12'h004, 32'h0, "R10 gap");

    // R7 clear
    wr(sa(2, 16), 32'h0);
    chk("R7 slot_valid cleared", 512'(slot_valid), 512'h0);
    #1 chk("R7 dp_valid cleared", 512'(dp_valid), 512'h0);
    rd(sa(2, 16), 32'h0, "R7 ctrl reads zero");

    // R4 key writable again after clear
    wr(sa(2, 0), 32'hCAFE_0000);
    exp_key[0] = 32'hCAFE_0000;
    #1 chk("R4 key after clear", dp_key, exp_key);

    // R3 slot addressing: last and first slot
    wr(sa(7, 17), 32'h7777_0007);
    wr(sa(0, 17), 32'h0000_AAAA);
    rd(sa(7, 17), 32'h7777_0007, "R3 slot7 aux");
    rd(sa(0, 17), 32'h0000_AAAA, "R3 slot0 aux");
    rd(sa(6, 17), 32'h0, "R3 slot6 untouched");
    rd(sa(2, 17), 32'hA5A5_0002, "R3 slot2 untouched");
    wr(sa(7, 16), 32'h8000_0101);
    chk("R3 R6 slot7 valid", 512'(slot_valid), 512'h80);
    dp_sel = 3'd7;
    #1 chk("R12 dp slot7 cap", 512'(dp_cap), 512'h01);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule